// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an eight-bit special-function control and status register that serves two timer/counters and two active-low external interrupt pins. Software reads the register as a byte. It can write the register as a byte, or change one bit at a time through bit addresses. The register holds a run-enable bit for each timer, which only software changes. It also holds a latched overflow flag for each timer. For each pin it holds a trigger-mode bit and a request flag.

A one-cycle overflow pulse from a timer sets that timer's flag. An acknowledge pulse from the interrupt controller, sent when it vectors to that source, clears the flag. Each pin is watched by a small two-state tracker: state SEEN_HIGH or state SEEN_LOW. The transition t_fall (SEEN_HIGH to SEEN_LOW) marks a high-to-low change of the pin. The transition t_rise goes back to SEEN_HIGH. Reset puts the tracker in SEEN_HIGH.

Every flag is a two-state machine with states FLG_CLEAR and FLG_PENDING. It has four transitions:
- t_set: a hardware set.
- t_ack: a hardware clear.
- t_swr: a software write.
- t_follow: in level mode, the state reloads from the inverted pin every cycle.

When events coincide, the order of priority is: hardware set, then acknowledge, then software write.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset the register reads 0x00, and run_en, tmr_irq and xint_irq are all 0.
- R2: A byte write with sfr_addr equal to 0x88 loads the register, subject to R8 and the flag priorities. Reads return the register when sfr_addr is 0x88 and 0x00 at any other address. A byte write to any other address changes nothing.
- R3: A bit write to address 0x88+k (k from 0 to 7) loads bit k from sfr_wdata[0] and leaves the other seven bits unchanged.
- R4: The bit layout is fixed as follows.
  - Bit 7: timer 1 overflow flag.
  - Bit 6: timer 1 run bit.
  - Bit 5: timer 0 overflow flag.
  - Bit 4: timer 0 run bit.
  - Bit 3: pin 1 request flag.
  - Bit 2: pin 1 mode bit.
  - Bit 1: pin 0 request flag.
  - Bit 0: pin 0 mode bit.

  The outputs run_en[c], tmr_irq[c] and xint_irq[c] mirror the bits of channel c.
- R5: If tmr_ovf[c] is high at a clock edge, timer flag c reads 1 after that edge. If ack_tmr[c] is high without an overflow, the flag reads 0 after the edge. An overflow pulse beats both an acknowledge and a software write.
- R6: Run bits change only through software writes. Overflows, pins and acknowledges never alter them.
- R7: With mode bit 1 (edge mode), a clock edge whose pin sample is 0, when the previous sample was 1, sets the request flag. A steady low or high pin, or a rising pin, does not set it. ack_xint[c] clears it unless a fall arrives in the same cycle.
- R8: With mode bit 0 (level mode), the request flag takes the inverted pin value at every clock edge. Acknowledges and software writes to it have no effect.
- R9: Software may set or clear a timer flag, and may set or clear a request flag in edge mode, by byte or bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Byte address, or bit address when sfr_wr_bit is high |
| sfr_wdata | input | 8 | Write data; bit 0 carries the value for bit writes |
| sfr_wr_byte | input | 1 | Byte write strobe |
| sfr_wr_bit | input | 1 | Bit write strobe |
| sfr_rdata | output | 8 | Read data |
| tmr_ovf | input | 2 | One-cycle overflow pulse per timer |
| xpin_n | input | 2 | Synchronised active-low interrupt pins |
| ack_tmr | input | 2 | Vector acknowledge per timer source |
| ack_xint | input | 2 | Vector acknowledge per pin source |
| run_en | output | 2 | Timer run enables |
| tmr_irq | output | 2 | Timer overflow requests |
| xint_irq | output | 2 | External pin requests |

## Verification
Directed sequences come first. They cover the reset value, the bit positions, single-bit writes, and writes to a foreign address. They also cover a held-low pin in edge mode, which separates true fall detection from level sensing. The same held-low pin in level mode separates following the pin from latching it. Coincident overflow and acknowledge pulses tell apart the set-over-clear priority. A long sweep driven by an arithmetic generator follows, mixing pin toggles, pulses, acknowledges, mode changes and both write forms. After every edge, every field is compared with a model computed from the requirements.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

    localparam int NCH = 2;
    localparam int REG_W = 8;

    typedef enum logic {
        SEEN_HIGH = 1'b0,
        SEEN_LOW  = 1'b1
    } pin_state_e;

    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;

    function automatic int unsigned ovf_pos(input int unsigned c);
        return 5 + 2 * c;
    endfunction

    function automatic int unsigned run_pos(input int unsigned c);
        return 4 + 2 * c;
    endfunction

    function automatic int unsigned xreq_pos(input int unsigned c);
        return 1 + 2 * c;
    endfunction

    function automatic int unsigned xmode_pos(input int unsigned c);
        return 2 * c;
    endfunction

endpackage

// File: rtl/sfr_wr_decode.sv
module sfr_wr_decode #(
    parameter logic [7:0] BASE  = 8'h88,
    parameter int         REG_W = 8
) (
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             wr_byte,
    input  logic             wr_bit,
    output logic [REG_W-1:0] bit_we,
    output logic [REG_W-1:0] bit_wv
);
    localparam int SEL_W = $clog2(REG_W);

    logic byte_hit;
    logic bit_hit;

    assign byte_hit = wr_byte && (addr == BASE);
    assign bit_hit  = wr_bit && (addr[7:SEL_W] == BASE[7:SEL_W]);

    always_comb begin
        bit_we = '0;
        bit_wv = '0;
        if (byte_hit) begin
            bit_we = '1;
            bit_wv = wdata[REG_W-1:0];
        end else if (bit_hit) begin
            bit_we[addr[SEL_W-1:0]] = 1'b1;
            bit_wv = {REG_W{wdata[0]}};
        end
    end
endmodule

// File: rtl/pin_fall_fsm.sv
module pin_fall_fsm
    import tmr_xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic seen_hi,
    output logic fall
);
    pin_state_e state_q;
    pin_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEEN_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEEN_HIGH: if (!pin_n) state_d = SEEN_LOW;   // t_fall
            SEEN_LOW:  if (pin_n)  state_d = SEEN_HIGH;  // t_rise
            default:   state_d = SEEN_HIGH;
        endcase
    end

    always_comb begin
        seen_hi = (state_q == SEEN_HIGH);
        fall    = (state_q == SEEN_HIGH) && !pin_n;
    end
endmodule

// File: rtl/req_flag_fsm.sv
module req_flag_fsm
    import tmr_xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic sw_we,
    input  logic sw_val,
    input  logic follow_en,
    input  logic follow_val,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (follow_en) begin
            state_d = follow_val ? FLG_PENDING : FLG_CLEAR;        // t_follow
        end else begin
            unique case (state_q)
                FLG_CLEAR: begin
                    if (hw_set)                  state_d = FLG_PENDING; // t_set
                    else if (hw_clr)             state_d = FLG_CLEAR;
                    else if (sw_we && sw_val)    state_d = FLG_PENDING; // t_swr
                end
                FLG_PENDING: begin
                    if (hw_set)                  state_d = FLG_PENDING;
                    else if (hw_clr)             state_d = FLG_CLEAR;   // t_ack
                    else if (sw_we && !sw_val)   state_d = FLG_CLEAR;   // t_swr
                end
                default: state_d = FLG_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag = (state_q == FLG_PENDING);
    end
endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
    import tmr_xint_pkg::*;
#(
    parameter logic [7:0] SFR_ADDR = 8'h88
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_wr_byte,
    input  logic       sfr_wr_bit,
    output logic [7:0] sfr_rdata,
    input  logic [1:0] tmr_ovf,
    input  logic [1:0] xpin_n,
    input  logic [1:0] ack_tmr,
    input  logic [1:0] ack_xint,
    output logic [1:0] run_en,
    output logic [1:0] tmr_irq,
    output logic [1:0] xint_irq
);
    logic [REG_W-1:0] bit_we;
    logic [REG_W-1:0] bit_wv;
    logic [NCH-1:0]   run_q;
    logic [NCH-1:0]   mode_q;
    logic [NCH-1:0]   seen_hi;
    logic [NCH-1:0]   fall;
    logic [REG_W-1:0] reg_view;

    sfr_wr_decode #(.BASE(SFR_ADDR), .REG_W(REG_W)) u_dec (
        .addr    (sfr_addr),
        .wdata   (sfr_wdata),
        .wr_byte (sfr_wr_byte),
        .wr_bit  (sfr_wr_bit),
        .bit_we  (bit_we),
        .bit_wv  (bit_wv)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned P_OVF  = ovf_pos(c);
        localparam int unsigned P_RUN  = run_pos(c);
        localparam int unsigned P_XREQ = xreq_pos(c);
        localparam int unsigned P_MODE = xmode_pos(c);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q[c]  <= 1'b0;
                mode_q[c] <= 1'b0;
            end else begin
                if (bit_we[P_RUN])  run_q[c]  <= bit_wv[P_RUN];
                if (bit_we[P_MODE]) mode_q[c] <= bit_wv[P_MODE];
            end
        end

        pin_fall_fsm u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (xpin_n[c]),
            .seen_hi (seen_hi[c]),
            .fall    (fall[c])
        );

        req_flag_fsm u_tflag (
            .clk        (clk),
            .rst_n      (rst_n),
            .hw_set     (tmr_ovf[c]),
            .hw_clr     (ack_tmr[c]),
            .sw_we      (bit_we[P_OVF]),
            .sw_val     (bit_wv[P_OVF]),
            .follow_en  (1'b0),
            .follow_val (1'b0),
            .flag       (tmr_irq[c])
        );

        req_flag_fsm u_xflag (
            .clk        (clk),
            .rst_n      (rst_n),
            .hw_set     (mode_q[c] && fall[c]),
            .hw_clr     (mode_q[c] && ack_xint[c]),
            .sw_we      (bit_we[P_XREQ]),
            .sw_val     (bit_wv[P_XREQ]),
            .follow_en  (!mode_q[c]),
            .follow_val (!xpin_n[c]),
            .flag       (xint_irq[c])
        );

        always_comb begin
            reg_view[P_OVF]  = tmr_irq[c];
            reg_view[P_RUN]  = run_q[c];
            reg_view[P_XREQ] = xint_irq[c];
            reg_view[P_MODE] = mode_q[c];
        end
    end

    assign run_en    = run_q;
    assign sfr_rdata = (sfr_addr == SFR_ADDR) ? reg_view : 8'h00;
endmodule

// File: rtl/tmr_xint_ctl_chk.sv
module tmr_xint_ctl_chk #(
    parameter logic [7:0] SFR_ADDR = 8'h88
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] sfr_addr,
    input logic       sfr_wr_byte,
    input logic       sfr_wr_bit,
    input logic [7:0] sfr_rdata,
    input logic [1:0] tmr_ovf,
    input logic [1:0] xpin_n,
    input logic [1:0] ack_tmr,
    input logic [1:0] ack_xint,
    input logic [1:0] run_en,
    input logic [1:0] tmr_irq,
    input logic [1:0] xint_irq,
    input logic [1:0] mode_q,
    input logic [1:0] seen_hi
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        localparam logic [2:0] RUN_BIT = 3'(4 + 2 * c);
        localparam int OVF_BIT = 5 + 2 * c;

        p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[c] |=> tmr_irq[c]);

        p_ovf_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_tmr[c] && !tmr_ovf[c]) |=> !tmr_irq[c]);

        p_run_sw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!(sfr_wr_byte && sfr_addr == SFR_ADDR) &&
             !(sfr_wr_bit && sfr_addr == {SFR_ADDR[7:3], RUN_BIT}))
            |=> $stable(run_en[c]));

        p_edge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[c] && seen_hi[c] && !xpin_n[c]) |=> xint_irq[c]);

        p_edge_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[c] && ack_xint[c] && !(seen_hi[c] && !xpin_n[c])) |=> !xint_irq[c]);

        p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[c] |=> (xint_irq[c] == !$past(xpin_n[c])));

        p_read_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sfr_addr == SFR_ADDR) |-> (sfr_rdata[OVF_BIT] == tmr_irq[c]));
    end
endmodule

bind tmr_xint_ctl tmr_xint_ctl_chk #(.SFR_ADDR(SFR_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_addr    (sfr_addr),
    .sfr_wr_byte (sfr_wr_byte),
    .sfr_wr_bit  (sfr_wr_bit),
    .sfr_rdata   (sfr_rdata),
    .tmr_ovf     (tmr_ovf),
    .xpin_n      (xpin_n),
    .ack_tmr     (ack_tmr),
    .ack_xint    (ack_xint),
    .run_en      (run_en),
    .tmr_irq     (tmr_irq),
    .xint_irq    (xint_irq),
    .mode_q      (mode_q),
    .seen_hi     (seen_hi)
);

// File: tb/test_tmr_xint_ctl.sv
`timescale 1ns/1ps
module test_tmr_xint_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h88;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_wr_byte = 1'b0;
    logic       sfr_wr_bit = 1'b0;
    logic [7:0] sfr_rdata;
    logic [1:0] tmr_ovf = 2'b00;
    logic [1:0] xpin_n = 2'b11;
    logic [1:0] ack_tmr = 2'b00;
    logic [1:0] ack_xint = 2'b00;
    logic [1:0] run_en;
    logic [1:0] tmr_irq;
    logic [1:0] xint_irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_reg = 8'h00;
    logic [1:0] prev_pin = 2'b11;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_xint_ctl i_tmr_xint_ctl (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_wr_byte(sfr_wr_byte), .sfr_wr_bit(sfr_wr_bit), .sfr_rdata(sfr_rdata),
        .tmr_ovf(tmr_ovf), .xpin_n(xpin_n), .ack_tmr(ack_tmr), .ack_xint(ack_xint),
        .run_en(run_en), .tmr_irq(tmr_irq), .xint_irq(xint_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 read", sfr_rdata, (sfr_addr == 8'h88) ? exp_reg : 8'h00);
        chk("R6 run_en", {6'd0, run_en}, {6'd0, exp_reg[6], exp_reg[4]});
        chk("R5 tmr_irq", {6'd0, tmr_irq}, {6'd0, exp_reg[7], exp_reg[5]});
        chk("R7 R8 xint_irq", {6'd0, xint_irq}, {6'd0, exp_reg[3], exp_reg[1]});
    endtask

    // One clock: drive at negedge, predict, sample at the next negedge.
    task automatic step(input logic [7:0] a, input logic [7:0] wd, input logic wb,
                        input logic wbit, input logic [1:0] ovf, input logic [1:0] pin,
                        input logic [1:0] at, input logic [1:0] ax);
        logic [7:0] we;
        logic [7:0] wv;
        logic [7:0] nx;
        sfr_addr = a; sfr_wdata = wd; sfr_wr_byte = wb; sfr_wr_bit = wbit;
        tmr_ovf = ovf; xpin_n = pin; ack_tmr = at; ack_xint = ax;
        we = 8'h00; wv = 8'h00;
        if (wb && a == 8'h88) begin
            we = 8'hFF; wv = wd;
        end else if (wbit && a[7:3] == 5'h11) begin
            we = 8'h01 << a[2:0]; wv = {8{wd[0]}};
        end
        nx = exp_reg;
        for (int c = 0; c < 2; c++) begin
            int pr; int pm; int po; int px;
            pr = 4 + 2 * c; pm = 2 * c; po = 5 + 2 * c; px = 1 + 2 * c;
            if (we[pr]) nx[pr] = wv[pr];
            if (we[pm]) nx[pm] = wv[pm];
            if (ovf[c])        nx[po] = 1'b1;
            else if (at[c])    nx[po] = 1'b0;
            else if (we[po])   nx[po] = wv[po];
            if (!exp_reg[pm])                      nx[px] = !pin[c];
            else if (prev_pin[c] && !pin[c])       nx[px] = 1'b1;
            else if (ax[c])                        nx[px] = 1'b0;
            else if (we[px])                       nx[px] = wv[px];
        end
        @(posedge clk);
        exp_reg = nx;
        prev_pin = pin;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input logic [1:0] pin);
        step(8'h88, 8'h00, 1'b0, 1'b0, 2'b00, pin, 2'b00, 2'b00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 reset read", sfr_rdata, 8'h00);
        chk("R1 reset outs", {2'b00, run_en, tmr_irq, xint_irq}, 8'h00);
        idle(2'b11);

        // R4: byte 0x50 enables both runs; 0x10 only timer 0; layout of modes
        step(8'h88, 8'h50, 1'b1, 1'b0, 2'b00, 2'b11, 2'b00, 2'b00);
        chk("R4 run bits", {6'd0, run_en}, 8'h03);
        step(8'h88, 8'h15, 1'b1, 1'b0, 2'b00, 2'b11, 2'b00, 2'b00);
        chk("R4 run0 at bit4", {6'd0, run_en}, 8'h01);
        chk("R4 modes at bits 0 and 2", sfr_rdata, 8'h15);

        // R3: bit write 0x8E sets run1 only
        step(8'h8E, 8'h01, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00, 2'b00);
        chk("R3 bit write", sfr_rdata, 8'h00);
        idle(2'b11);
        chk("R3 bit write", sfr_rdata, 8'h55);

        // R2: byte write elsewhere ignored
        step(8'h80, 8'hFF, 1'b1, 1'b0, 2'b00, 2'b11, 2'b00, 2'b00);
        idle(2'b11);
        chk("R2 foreign write", sfr_rdata, 8'h55);

        // R7: edge mode, fall then held low with acknowledge
        idle(2'b10);
        chk("R7 fall sets", {6'd0, xint_irq}, 8'h01);
        step(8'h88, 8'h00, 1'b0, 1'b0, 2'b00, 2'b10, 2'b00, 2'b01);
        chk("R7 ack clears", {6'd0, xint_irq}, 8'h00);
        idle(2'b10);
        idle(2'b10);
        chk("R7 held low no set", {6'd0, xint_irq}, 8'h00);
        idle(2'b11);
        chk("R7 rise no set", {6'd0, xint_irq}, 8'h00);

        // R9: software set of edge-mode request and timer flag
        step(8'h8B, 8'h01, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00, 2'b00);
        chk("R9 sw set request", {6'd0, xint_irq}, 8'h02);
        step(8'h8F, 8'h01, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00, 2'b00);
        chk("R9 sw set ovf", {6'd0, tmr_irq}, 8'h02);
        step(8'h8F, 8'h00, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00, 2'b00);
        chk("R9 sw clear ovf", {6'd0, tmr_irq}, 8'h00);

        // R5: overflow with simultaneous acknowledge -> set wins
        step(8'h88, 8'h00, 1'b0, 1'b0, 2'b01, 2'b11, 2'b01, 2'b00);
        chk("R5 set beats ack", {6'd0, tmr_irq}, 8'h01);
        step(8'h88, 8'h00, 1'b0, 1'b0, 2'b00, 2'b11, 2'b01, 2'b00);
        chk("R5 ack clears", {6'd0, tmr_irq}, 8'h00);

        // R8: level mode follows the pin, ignores ack and writes
        step(8'h88, 8'h00, 1'b1, 1'b0, 2'b00, 2'b11, 2'b00, 2'b00);
        idle(2'b10);
        chk("R8 low requests", {6'd0, xint_irq}, 8'h01);
        step(8'h89, 8'h00, 1'b0, 1'b1, 2'b00, 2'b10, 2'b00, 2'b01);
        chk("R8 ack and write ignored", {6'd0, xint_irq}, 8'h01);
        idle(2'b11);
        chk("R8 high drops", {6'd0, xint_irq}, 8'h00);
        chk("R6 run kept", {6'd0, run_en}, 8'h00);

        // Sweep: arithmetic generator over all inputs
        r = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            r = r * 32'd1103515245 + 32'd12345;
            case (r[25:24])
                2'd0, 2'd1: a = 8'h88;
                2'd2:       a = {5'h11, r[28:26]};
                default:    a = r[29] ? 8'h80 : 8'h89;
            endcase
            step(a, r[23:16], r[15:13] == 3'd0, r[12:11] == 2'd0,
                 r[10:9] & {r[8], r[8]}, r[7] ? r[6:5] : xpin_n,
                 r[4:3] & {r[2], r[2]}, r[1:0] & {r[31], r[31]});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule